// File: doc/BRIEF.md
# PWM Fault Input Conditioner

This block turns six raw external fault lines into clean fault-active signals for a PWM controller. Every line is brought into the clock domain by a two-stage synchroniser. It can then pass through a glitch filter that needs several cycles of a steady level, and it is compared against a programmable active level. A fault then works in one of two ways. In live mode it follows the condition directly. In sticky mode it holds until the condition has gone away and software has also acknowledged it.

Software reaches the block over a simple word-addressed register bus. A configuration word holds three six-bit fields: the active level, the sticky selection and the filter enable. Two external protection flags block writes to this word. A read-only status word shows the fault vector, and a write-one clear word acknowledges sticky faults.

Top module: `pwm_fault_cond`

## Requirements
- R1: After reset the configuration word reads 0, no sticky fault is held, and with every input held high the fault vector and the status word (address 1) are both 0.
- R2: Level bit y (configuration bit y, y = 0..5) selects the active input level for fault y: 0 makes a low input active and 1 makes a high input active.
- R3: With filtering off, a change on input y first shows on fault_act[y] after the second rising clock edge following it.
- R4: With filter bit y set (configuration bit 16+y), the filtered level changes only after the synchronised input has differed from it for 4 consecutive cycles. A change then shows on fault_act[y] after the sixth edge, and a 3-cycle pulse has no effect.
- R5: With filter bit y clear, the filter is bypassed and R3 timing applies.
- R6: With sticky bit y clear (configuration bit 8+y), fault_act[y] follows the condition and drops as soon as the condition goes away.
- R7: With sticky bit y set, fault_act[y] stays 1 after the condition goes away. It drops only after a write of 1 to bit y of the clear word (address 2) made while the condition is absent.
- R8: A clear written while the condition of a sticky fault is still present has no effect, and the fault stays active.
- R9: A write to the configuration word (address 0) is discarded while wp_sw or wp_hw is high.
- R10: Configuration bits 31:22, 15:14 and 7:6 are not stored and read back as 0.
- R11: Address 1 reads fault_act in bits 5:0 with the upper bits 0. Address 2 reads 0.
- R12: Writes are accepted in any order. Setting a sticky bit while the level bit still marks the idle input as active latches a fault that outlasts the later level change until a clear is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 configuration, 1 status, 2 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wp_sw | input | 1 | Software write-protect flag |
| wp_hw | input | 1 | Hardware write-protect flag |
| fault_in | input | 6 | Raw asynchronous fault lines |
| fault_act | output | 6 | Per-input fault-active vector |

## Verification
The hardest situation to reach is a sticky fault where the condition comes back, a clear arrives while it is present, and the condition then goes away. Only a second clear should release the fault. The bench walks one input through that exact sequence and samples after each step. It also builds the spurious latch on purpose by setting the sticky bit before the level bit. The filter threshold is checked with a pulse one cycle too short, and with a steady level sampled on the edges just before and just after the change.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NFLT       = 6;
  localparam int FLT_STABLE = 4;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 2;
  localparam int LVL_LSB    = 0;
  localparam int STK_LSB    = 8;
  localparam int FIL_LSB    = 16;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pfc_filter.sv
module pfc_filter #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (STABLE > 2) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (din == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      out_d = din;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/pfc_chan.sv
module pfc_chan #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_in,
  input  logic lvl,
  input  logic sticky,
  input  logic filt_en,
  input  logic clr,
  output logic cond,
  output logic active
);
  logic filt_out;
  logic sel;
  logic hold_q, hold_d;

  pfc_filter #(.STABLE(STABLE)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (s_in),
    .dout (filt_out)
  );

  assign sel  = filt_en ? filt_out : s_in;
  assign cond = ~(sel ^ lvl);

  always_comb begin
    hold_d = sticky & (hold_q | cond);
    if (clr && !cond) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign active = cond | (sticky & hold_q);
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond
  import pfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_sw,
  input  logic              wp_hw,
  input  logic [NFLT-1:0]   fault_in,
  output logic [NFLT-1:0]   fault_act
);
  logic [NFLT-1:0] lvl_q, stk_q, fil_q;
  logic [NFLT-1:0] lvl_d, stk_d, fil_d;
  logic [NFLT-1:0] sync_v, cond_vec, clr_v;
  logic            cfg_en;
  logic            unused_wbits;

  assign cfg_en = bus_wr && (bus_addr == A_CFG) && !wp_sw && !wp_hw;
  assign clr_v  = (bus_wr && (bus_addr == A_CLR)) ? bus_wdata[NFLT-1:0] : '0;
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    lvl_d = lvl_q;
    stk_d = stk_q;
    fil_d = fil_q;
    if (cfg_en) begin
      lvl_d = bus_wdata[LVL_LSB +: NFLT];
      stk_d = bus_wdata[STK_LSB +: NFLT];
      fil_d = bus_wdata[FIL_LSB +: NFLT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      stk_q <= '0;
      fil_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      stk_q <= stk_d;
      fil_q <= fil_d;
    end
  end

  pfc_sync #(.W(NFLT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (fault_in),
    .q    (sync_v)
  );

  for (genvar y = 0; y < NFLT; y++) begin : g_chan
    pfc_chan #(.STABLE(FLT_STABLE)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .s_in   (sync_v[y]),
      .lvl    (lvl_q[y]),
      .sticky (stk_q[y]),
      .filt_en(fil_q[y]),
      .clr    (clr_v[y]),
      .cond   (cond_vec[y]),
      .active (fault_act[y])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[LVL_LSB +: NFLT] = lvl_q;
        bus_rdata[STK_LSB +: NFLT] = stk_q;
        bus_rdata[FIL_LSB +: NFLT] = fil_q;
      end
      A_STAT:  bus_rdata[NFLT-1:0] = fault_act;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk
  import pfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wp_sw,
  input logic              wp_hw,
  input logic [NFLT-1:0]   fault_act,
  input logic [NFLT-1:0]   lvl_q,
  input logic [NFLT-1:0]   stk_q,
  input logic [NFLT-1:0]   fil_q,
  input logic [NFLT-1:0]   cond_vec
);
  logic cfg_wr, clr_wr;
  assign cfg_wr = bus_wr && (bus_addr == A_CFG);
  assign clr_wr = bus_wr && (bus_addr == A_CLR);

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (wp_sw || wp_hw)) |=> ($stable(lvl_q) && $stable(stk_q) && $stable(fil_q)));

  // R10
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wp_sw && !wp_hw) |=>
      (lvl_q == $past(bus_wdata[LVL_LSB +: NFLT]) && stk_q == $past(bus_wdata[STK_LSB +: NFLT])
       && fil_q == $past(bus_wdata[FIL_LSB +: NFLT])));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !cfg_wr) |=> (($past(fault_act & stk_q) & ~fault_act) == '0));

  // R8
  clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (($past(cond_vec & stk_q & bus_wdata[NFLT-1:0]) & ~fault_act) == '0));

  // R11
  stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_CFG) |-> (bus_rdata[DATA_W-1:NFLT] == '0));
endmodule

bind pwm_fault_cond pfc_chk u_chk (.*);

// File: tb/sim_pwm_fault_cond.sv
module sim_pwm_fault_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wp_sw = 1'b0;
  logic        wp_hw = 1'b0;
  logic [5:0]  fault_in = 6'h3F;
  logic [5:0]  fault_act;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_fault_cond u0 (.*);

  // {config word, input vector, expected fault vector}
  localparam logic [43:0] VEC [7] = '{
    {32'h0000_0000, 6'h3F, 6'h00},
    {32'h0000_0000, 6'h00, 6'h3F},
    {32'h0000_003F, 6'h15, 6'h15},
    {32'h0000_003F, 6'h2A, 6'h2A},
    {32'h003F_003F, 6'h0F, 6'h0F},
    {32'h003F_0000, 6'h30, 6'h0F},
    {32'h0000_0007, 6'h05, 6'h3D}
  };

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    rd(2'd0, r); chk("R1 cfg", r, 0);
    rd(2'd1, r); chk("R1 status", r, 0);
    chk("R1 act", {26'b0, fault_act}, 0);

    // table walk: R2, R5, R6, R4 steady state, R11
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, VEC[i][43:12]);
      fault_in = VEC[i][11:6];
      tick(10);
      chk("R2/R6 vector act", {26'b0, fault_act}, {26'b0, VEC[i][5:0]});
      rd(2'd1, r); chk("R11 status", r, {26'b0, VEC[i][5:0]});
    end
    rd(2'd2, r); chk("R11 clear reads 0", r, 0);

    // R3 / R5: unfiltered latency
    wr(2'd0, 32'h3F); fault_in = 6'h00; tick(6);
    fault_in[0] = 1'b1;
    tick(1); chk("R3 edge1", fault_act[0], 0);
    tick(1); chk("R5 edge2", fault_act[0], 1);

    // R4: filtered pulse and threshold
    wr(2'd0, 32'h0001_003F); fault_in = 6'h00; tick(10);
    fault_in[0] = 1'b1; tick(3); fault_in[0] = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (fault_act[0] !== 1'b0) chk("R4 short pulse", fault_act[0], 0);
      tick(1);
    end
    chk("R4 short pulse end", fault_act[0], 0);
    fault_in[0] = 1'b1;
    tick(5); chk("R4 edge5", fault_act[0], 0);
    tick(1); chk("R4 edge6", fault_act[0], 1);

    // R7 / R8 sticky sequence on input 1
    wr(2'd0, 32'h0000_003F); wr(2'd0, 32'h0000_023F);
    fault_in = 6'h00; tick(6);
    fault_in[1] = 1'b1; tick(4);
    chk("R7 set", fault_act[1], 1);
    wr(2'd2, 32'h2); tick(1);
    chk("R8 clear ignored", fault_act[1], 1);
    fault_in[1] = 1'b0; tick(6);
    chk("R7 hold after removal", fault_act[1], 1);
    wr(2'd2, 32'h2);
    chk("R7 released", fault_act[1], 0);
    rd(2'd1, r); chk("R7 status", r, 0);

    // R9 write protect
    wp_sw = 1'b1; wr(2'd0, 32'h0012_3400); wp_sw = 1'b0;
    rd(2'd0, r); chk("R9 sw protect", r, 32'h0000_023F);
    wp_hw = 1'b1; wr(2'd0, 32'h0001_0001); wp_hw = 1'b0;
    rd(2'd0, r); chk("R9 hw protect", r, 32'h0000_023F);

    // R10 unused bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); chk("R10 readback", r, 32'h003F_3F3F);

    // R12 wrong order leaves a latch
    wr(2'd0, 32'h0); fault_in = 6'h00; tick(6);
    wr(2'd0, 32'h0000_0400);
    wr(2'd0, 32'h0000_0404); tick(2);
    chk("R12 spurious latch", fault_act[2], 1);
    wr(2'd2, 32'h4);
    chk("R12 cleared", fault_act[2], 0);
    wr(2'd0, 32'h0); tick(2);
    wr(2'd0, 32'h0000_0004); wr(2'd0, 32'h0000_0404); tick(2);
    chk("R12 right order", fault_act[2], 0);

    done = 1'b1;
    summary();
  end
endmodule